// File: doc/BRIEF.md
# Region-Attribute Store Coalescing Buffer

This block sits between a processor's store port and an outgoing bus write channel. It holds a few stores the bus has not yet taken. When a new store targets an address whose memory region is marked as ordinary memory, the block may fold that store into a pending entry, so the bus sees only the final value. When the region is marked as having side effects (I/O), every store keeps its own entry and reaches the bus on its own, in the order it was issued.

Each region's behaviour comes from a 32-bit attribute word that software writes through a simple write-enable port. The word covers sixteen equal regions of the address space, with two bits for each region. A fence input stalls new stores until everything already buffered has left on the bus. It then reports completion.

Top module: `store_coalesce_buf`

## Requirements
- R1: After reset the attribute word is zero, so every region is non-volatile and non-cacheable, and the bus channel is idle (bus_valid low).
- R2: The region of an address is address[31:28]. Region n reads attribute bit 2n as cacheable and bit 2n+1 as volatile. With the word 0xAAAA0000, regions 8 to 15 are volatile and regions 0 to 7 are not.
- R3: A store to a non-volatile region whose address equals that of a pending entry other than the bus head is merged into that entry and adds no new entry. Only the merged value is issued.
- R4: A merge writes only the byte lanes whose strobe is set in the new store. The merged entry's strobes are the OR of the old and new strobes (strobe bit b covers data[8b+7:8b]).
- R5: The entry at the bus head is presented on the bus and is never a merge target, so a store to the head's address adds a new entry.
- R6: A store to a volatile region always takes a new entry and is issued to the bus on its own.
- R7: Entries leave on the bus in the order they were allocated.
- R8: With all DEPTH (4) entries in use, st_ready is low unless the store can merge. If a merge is possible, st_ready stays high.
- R9: bus_valid is high whenever an entry is pending. While bus_ready is low, the head's address, data and strobes hold steady. An entry leaves only on a cycle where bus_valid and bus_ready are both high.
- R10: An attribute write takes effect for stores accepted from the following cycle onward. A store accepted in the same cycle as the write uses the previous attributes.
- R11: The cacheable bit does not affect merging. It is carried with each entry and appears on bus_cacheable.
- R12: While fence_req is high and an entry is pending, st_ready is low. fence_done is high exactly when fence_req is high and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attr_we | input | 1 | Write enable for the region attribute word |
| attr_wdata | input | 32 | New attribute word, two bits per region |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | 32 | Store byte address |
| st_data | input | 32 | Store data |
| st_strb | input | 4 | Store byte strobes |
| fence_req | input | 1 | Request to drain every pending store |
| fence_done | output | 1 | Fence requested and buffer empty |
| bus_valid | output | 1 | Head entry offered to the bus |
| bus_ready | input | 1 | Bus takes the head entry |
| bus_addr | output | 32 | Head entry address |
| bus_data | output | 32 | Head entry data |
| bus_strb | output | 4 | Head entry byte strobes |
| bus_cacheable | output | 1 | Cacheable attribute captured with the head entry |

## Verification
The bench builds the block with its default parameters: four entries, sixteen regions, and 32-bit address and data. A depth of four means a handful of stalled stores fills the buffer. This makes the full-buffer stall and merge-while-full cases reachable in a few cycles. With sixteen regions, one attribute word can split the space into coalescing and volatile halves, so both behaviours can be exercised side by side. The bus ready line is held low while stores pile up and then released. Merges, ordering and fence completion are therefore all judged from the sequence of handshakes on the bus.

// File: rtl/scb_pkg.sv
package scb_pkg;
    // Layout of one region's attribute pair inside the attribute word
    localparam int unsigned ATTR_CACHE_BIT  = 0;
    localparam int unsigned ATTR_VOL_BIT    = 1;
    localparam int unsigned ATTR_PAIR_WIDTH = 2;
endpackage

// File: rtl/scb_region_attr.sv
module scb_region_attr
    import scb_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned REGION_BITS = 4
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          we,
    input  logic [(ATTR_PAIR_WIDTH<<REGION_BITS)-1:0]     wdata,
    input  logic [ADDR_W-1:0]                             lookup_addr,
    output logic                                          is_volatile,
    output logic                                          is_cacheable
);
    localparam int unsigned NUM_REGIONS = 1 << REGION_BITS;
    localparam int unsigned ATTR_W      = ATTR_PAIR_WIDTH * NUM_REGIONS;

    typedef struct packed {
        logic [ATTR_W-1:0] attr;
    } attr_state_t;

    attr_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (we) begin
            state_d.attr = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Split the word into one flag per region for each attribute
    logic [NUM_REGIONS-1:0] vol_map;
    logic [NUM_REGIONS-1:0] cach_map;

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        assign vol_map[r]  = state_q.attr[r*ATTR_PAIR_WIDTH + ATTR_VOL_BIT];
        assign cach_map[r] = state_q.attr[r*ATTR_PAIR_WIDTH + ATTR_CACHE_BIT];
    end

    logic [REGION_BITS-1:0] region;
    assign region       = lookup_addr[ADDR_W-1 -: REGION_BITS];
    assign is_volatile  = vol_map[region];
    assign is_cacheable = cach_map[region];
endmodule

// File: rtl/scb_match.sv
module scb_match #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DEPTH  = 4,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0]             cand,
    input  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
    input  logic [ADDR_W-1:0]            key,
    output logic                         hit,
    output logic [PTR_W-1:0]             hit_idx
);
    logic [DEPTH-1:0] hit_vec;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit_vec[i] = cand[i] && (slot_addr[i] == key);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) begin
                hit_idx = PTR_W'(i);
            end
        end
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/store_coalesce_buf.sv
module store_coalesce_buf
    import scb_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned DEPTH       = 4,
    parameter int unsigned REGION_BITS = 4,
    localparam int unsigned STRB_W     = DATA_W / 8,
    localparam int unsigned ATTR_W     = ATTR_PAIR_WIDTH << REGION_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              attr_we,
    input  logic [ATTR_W-1:0] attr_wdata,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic [STRB_W-1:0] st_strb,
    input  logic              fence_req,
    output logic              fence_done,
    output logic              bus_valid,
    input  logic              bus_ready,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    output logic [STRB_W-1:0] bus_strb,
    output logic              bus_cacheable
);
    // DEPTH is expected to be a power of two so pointers wrap naturally
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
        logic              vol;
        logic              cach;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
        logic [PTR_W-1:0]   head;
        logic [CNT_W-1:0]   cnt;
    } buf_state_t;

    buf_state_t state_d, state_q;

    // Region attributes of the incoming store
    logic st_vol;
    logic st_cach;

    scb_region_attr #(
        .ADDR_W      (ADDR_W),
        .REGION_BITS (REGION_BITS)
    ) u_attr (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (attr_we),
        .wdata        (attr_wdata),
        .lookup_addr  (st_addr),
        .is_volatile  (st_vol),
        .is_cacheable (st_cach)
    );

    // Candidate slots for merging: occupied, not the bus head, not volatile
    logic [DEPTH-1:0]             cand;
    logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [PTR_W-1:0] age;
        logic             occupied;
        assign age          = PTR_W'(i) - state_q.head;
        assign occupied     = CNT_W'(age) < state_q.cnt;
        assign cand[i]      = occupied && (age != '0) && !state_q.ent[i].vol;
        assign slot_addr[i] = state_q.ent[i].addr;
    end

    logic             match_hit;
    logic [PTR_W-1:0] merge_idx;

    scb_match #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH)
    ) u_match (
        .cand      (cand),
        .slot_addr (slot_addr),
        .key       (st_addr),
        .hit       (match_hit),
        .hit_idx   (merge_idx)
    );

    logic [CNT_W-1:0] fill;
    logic             merge_ok;
    logic             full;
    logic             fence_block;
    logic             accept;
    logic             push;
    logic             pop;

    assign fill        = state_q.cnt;
    assign merge_ok    = match_hit && !st_vol;
    assign full        = (fill == CNT_W'(DEPTH));
    assign fence_block = fence_req && (fill != '0);
    assign st_ready    = !fence_block && (merge_ok || !full);
    assign accept      = st_valid && st_ready;
    assign push        = accept && !merge_ok;
    assign pop         = bus_valid && bus_ready;

    assign bus_valid     = (fill != '0);
    assign bus_addr      = state_q.ent[state_q.head].addr;
    assign bus_data      = state_q.ent[state_q.head].data;
    assign bus_strb      = state_q.ent[state_q.head].strb;
    assign bus_cacheable = state_q.ent[state_q.head].cach;
    assign fence_done    = fence_req && (fill == '0);

    always_comb begin
        logic [PTR_W-1:0] tail;
        state_d = state_q;
        tail    = state_q.head + PTR_W'(state_q.cnt);

        if (accept && merge_ok) begin
            for (int b = 0; b < STRB_W; b++) begin
                if (st_strb[b]) begin
                    state_d.ent[merge_idx].data[b*8 +: 8] = st_data[b*8 +: 8];
                end
            end
            state_d.ent[merge_idx].strb = state_q.ent[merge_idx].strb | st_strb;
        end else if (push) begin
            state_d.ent[tail].addr = st_addr;
            state_d.ent[tail].data = st_data;
            state_d.ent[tail].strb = st_strb;
            state_d.ent[tail].vol  = st_vol;
            state_d.ent[tail].cach = st_cach;
        end

        if (pop) begin
            state_d.head = state_q.head + PTR_W'(1);
        end

        state_d.cnt = state_q.cnt + CNT_W'(push) - CNT_W'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/scb_checker.sv
module scb_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned STRB_W = 4,
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_valid,
    input logic              st_ready,
    input logic              st_vol,
    input logic              merge_ok,
    input logic              fence_req,
    input logic              fence_done,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_data,
    input logic [STRB_W-1:0] bus_strb,
    input logic [CNT_W-1:0]  fill
);
    AST_HEAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_data) && $stable(bus_strb)); // R9

    AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == CNT_W'(DEPTH)) && !merge_ok |-> !st_ready); // R8

    AST_VOLATILE_ALLOCATES: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && st_ready && st_vol && !(bus_valid && bus_ready) |=> fill == CNT_W'($past(fill) + 1'b1)); // R6

    AST_MERGE_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && st_ready && merge_ok && !(bus_valid && bus_ready) |=> fill == $past(fill)); // R3

    AST_FENCE_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |-> !bus_valid); // R12

    AST_FENCE_HOLDS_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        fence_req && bus_valid |-> !st_ready); // R12
endmodule

bind store_coalesce_buf scb_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .STRB_W (STRB_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_valid   (st_valid),
    .st_ready   (st_ready),
    .st_vol     (st_vol),
    .merge_ok   (merge_ok),
    .fence_req  (fence_req),
    .fence_done (fence_done),
    .bus_valid  (bus_valid),
    .bus_ready  (bus_ready),
    .bus_addr   (bus_addr),
    .bus_data   (bus_data),
    .bus_strb   (bus_strb),
    .fill       (fill)
);

// File: tb/tb_store_coalesce_buf.sv
module tb_store_coalesce_buf;
    logic        clk;
    logic        rst_n;
    logic        attr_we;
    logic [31:0] attr_wdata;
    logic        st_valid;
    logic        st_ready;
    logic [31:0] st_addr;
    logic [31:0] st_data;
    logic [3:0]  st_strb;
    logic        fence_req;
    logic        fence_done;
    logic        bus_valid;
    logic        bus_ready;
    logic [31:0] bus_addr;
    logic [31:0] bus_data;
    logic [3:0]  bus_strb;
    logic        bus_cacheable;

    store_coalesce_buf dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .attr_we       (attr_we),
        .attr_wdata    (attr_wdata),
        .st_valid      (st_valid),
        .st_ready      (st_ready),
        .st_addr       (st_addr),
        .st_data       (st_data),
        .st_strb       (st_strb),
        .fence_req     (fence_req),
        .fence_done    (fence_done),
        .bus_valid     (bus_valid),
        .bus_ready     (bus_ready),
        .bus_addr      (bus_addr),
        .bus_data      (bus_data),
        .bus_strb      (bus_strb),
        .bus_cacheable (bus_cacheable)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    // Record of bus handshakes and the sequence each test expects
    logic [31:0] mon_addr [0:31];
    logic [31:0] mon_data [0:31];
    logic [3:0]  mon_strb [0:31];
    logic        mon_cach [0:31];
    int          mon_n = 0;
    logic [31:0] exp_addr [0:31];
    logic [31:0] exp_data [0:31];
    logic [3:0]  exp_strb [0:31];
    logic        exp_cach [0:31];
    int          exp_n = 0;

    always @(negedge clk) begin
        #5;
        if (rst_n && bus_valid && bus_ready && mon_n < 32) begin
            mon_addr[mon_n] = bus_addr;
            mon_data[mon_n] = bus_data;
            mon_strb[mon_n] = bus_strb;
            mon_cach[mon_n] = bus_cacheable;
            mon_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic expect_wr(input logic [31:0] a, input logic [31:0] d,
                             input logic [3:0] s, input logic c);
        exp_addr[exp_n] = a;
        exp_data[exp_n] = d;
        exp_strb[exp_n] = s;
        exp_cach[exp_n] = c;
        exp_n++;
    endtask

    // Called at a negedge: present a store and hold it until accepted
    task automatic send(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
        st_valid = 1'b1;
        st_addr  = a;
        st_data  = d;
        st_strb  = s;
        #1;
        while (!st_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic probe_ready(input logic [31:0] a, output logic rdy);
        st_valid = 1'b1;
        st_addr  = a;
        st_data  = 32'h0;
        st_strb  = 4'hF;
        #1;
        rdy      = st_ready;
        st_valid = 1'b0;
    endtask

    task automatic write_attr(input logic [31:0] w);
        attr_we    = 1'b1;
        attr_wdata = w;
        @(posedge clk);
        @(negedge clk);
        attr_we    = 1'b0;
    endtask

    // Open the bus, let everything drain, then compare against expectations
    task automatic drain_and_compare(input string req);
        bus_ready = 1'b1;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            #6;
            if (!bus_valid) break;
        end
        @(negedge clk);
        bus_ready = 1'b0;
        chk(mon_n == exp_n, req, "write count", 32'(mon_n), 32'(exp_n));
        for (int k = 0; k < exp_n && k < mon_n; k++) begin
            chk(mon_addr[k] == exp_addr[k], req, "addr", mon_addr[k], exp_addr[k]);
            chk(mon_data[k] == exp_data[k], req, "data", mon_data[k], exp_data[k]);
            chk(mon_strb[k] == exp_strb[k], req, "strb", 32'(mon_strb[k]), 32'(exp_strb[k]));
            chk(mon_cach[k] == exp_cach[k], req, "cacheable", 32'(mon_cach[k]), 32'(exp_cach[k]));
        end
        mon_n = 0;
        exp_n = 0;
    endtask

    task automatic t_reset;
        chk(bus_valid == 1'b0, "R1", "bus_valid after reset", 32'(bus_valid), 32'h0);
        chk(st_ready == 1'b1, "R1", "st_ready after reset", 32'(st_ready), 32'h1);
        chk(fence_done == 1'b0, "R12", "fence_done without request", 32'(fence_done), 32'h0);
        // R1: region 15 is non-volatile at reset, so a repeat store coalesces
        send(32'hF000_0000, 32'h0000_0001, 4'hF);
        send(32'hF000_0000, 32'h0000_0002, 4'hF);
        send(32'hF000_0000, 32'h0000_0003, 4'hF);
        expect_wr(32'hF000_0000, 32'h0000_0001, 4'hF, 1'b0);
        expect_wr(32'hF000_0000, 32'h0000_0003, 4'hF, 1'b0);
        drain_and_compare("R1");
    endtask

    task automatic t_coalesce;
        logic [31:0] a0;
        send(32'h0000_0100, 32'h1, 4'hF);
        send(32'h0000_0200, 32'h2, 4'hF);
        send(32'h0000_0100, 32'h3, 4'hF);   // R5: head holds this address, new entry
        send(32'h0000_0100, 32'h4, 4'hF);   // R3: merges into the previous one
        a0 = bus_addr;
        @(negedge clk);
        chk(bus_valid && bus_addr == a0 && bus_data == 32'h1, "R9", "head stable while stalled",
            bus_data, 32'h1);
        send(32'h0000_0200, 32'h5, 4'hF);   // R3: merges into the second entry
        expect_wr(32'h0000_0100, 32'h1, 4'hF, 1'b0);
        expect_wr(32'h0000_0200, 32'h5, 4'hF, 1'b0);
        expect_wr(32'h0000_0100, 32'h4, 4'hF, 1'b0);
        drain_and_compare("R3 R5 R7");
    endtask

    task automatic t_bytes;
        send(32'h0000_0300, 32'h1234_5678, 4'hF);
        send(32'h0000_0304, 32'h0000_00AA, 4'b0001);
        send(32'h0000_0304, 32'h00BB_0000, 4'b0100);
        send(32'h0000_0304, 32'hCC00_00DD, 4'b1001);
        expect_wr(32'h0000_0300, 32'h1234_5678, 4'hF, 1'b0);
        expect_wr(32'h0000_0304, 32'hCCBB_00DD, 4'b1101, 1'b0);
        drain_and_compare("R4");
    endtask

    task automatic t_volatile;
        write_attr(32'hAAAA_0000);
        send(32'h8000_0010, 32'h1, 4'hF);
        send(32'h8000_0010, 32'h2, 4'hF);
        send(32'h8000_0010, 32'h3, 4'hF);
        send(32'h7000_0010, 32'h4, 4'hF);   // R2: region 7 stays mergeable
        send(32'h7000_0010, 32'h5, 4'hF);
        send(32'h7000_0010, 32'h6, 4'hF);
        expect_wr(32'h8000_0010, 32'h1, 4'hF, 1'b0);
        expect_wr(32'h8000_0010, 32'h2, 4'hF, 1'b0);
        expect_wr(32'h8000_0010, 32'h3, 4'hF, 1'b0);
        expect_wr(32'h7000_0010, 32'h6, 4'hF, 1'b0);
        drain_and_compare("R6 R2");
    endtask

    task automatic t_full;
        logic rdy;
        // Volatile region: four entries fill the buffer
        for (int i = 0; i < 4; i++) begin
            send(32'h9000_0000 + 32'(i * 4), 32'(i + 16), 4'hF);
            expect_wr(32'h9000_0000 + 32'(i * 4), 32'(i + 16), 4'hF, 1'b0);
        end
        probe_ready(32'h9000_0004, rdy);
        chk(rdy == 1'b0, "R8", "full volatile store stalls", 32'(rdy), 32'h0);
        probe_ready(32'h1000_0000, rdy);
        chk(rdy == 1'b0, "R8", "full without match stalls", 32'(rdy), 32'h0);
        @(negedge clk);
        drain_and_compare("R8 R7");
        // Non-volatile region: full buffer still takes a mergeable store
        write_attr(32'h0000_0000);
        for (int i = 0; i < 4; i++) begin
            send(32'h1000_0000 + 32'(i * 4), 32'(i + 32), 4'hF);
        end
        probe_ready(32'h1000_0008, rdy);
        chk(rdy == 1'b1, "R8", "full but mergeable accepted", 32'(rdy), 32'h1);
        @(negedge clk);
        send(32'h1000_0008, 32'h0000_0077, 4'hF);
        probe_ready(32'h1000_0000, rdy);
        chk(rdy == 1'b0, "R5", "full, match only at head", 32'(rdy), 32'h0);
        @(negedge clk);
        expect_wr(32'h1000_0000, 32'd32, 4'hF, 1'b0);
        expect_wr(32'h1000_0004, 32'd33, 4'hF, 1'b0);
        expect_wr(32'h1000_0008, 32'h0000_0077, 4'hF, 1'b0);
        expect_wr(32'h1000_000C, 32'd35, 4'hF, 1'b0);
        drain_and_compare("R8 R3");
    endtask

    task automatic t_attr_timing;
        send(32'h9000_0000, 32'hD0, 4'hF);
        send(32'h9000_0004, 32'hD1, 4'hF);
        // Attribute write and merging store in the same cycle
        attr_we    = 1'b1;
        attr_wdata = 32'hAAAA_0000;
        st_valid   = 1'b1;
        st_addr    = 32'h9000_0004;
        st_data    = 32'hD2;
        st_strb    = 4'hF;
        #1;
        chk(st_ready == 1'b1, "R10", "store in write cycle uses old attribute", 32'(st_ready), 32'h1);
        @(posedge clk);
        @(negedge clk);
        attr_we  = 1'b0;
        st_valid = 1'b0;
        send(32'h9000_0004, 32'hD3, 4'hF);
        expect_wr(32'h9000_0000, 32'hD0, 4'hF, 1'b0);
        expect_wr(32'h9000_0004, 32'hD2, 4'hF, 1'b0);
        expect_wr(32'h9000_0004, 32'hD3, 4'hF, 1'b0);
        drain_and_compare("R10");
    endtask

    task automatic t_cacheable;
        write_attr(32'h5555_5555);
        send(32'h2000_0000, 32'h1, 4'hF);
        send(32'h2000_0040, 32'h2, 4'hF);
        send(32'h2000_0040, 32'h3, 4'hF);
        expect_wr(32'h2000_0000, 32'h1, 4'hF, 1'b1);
        expect_wr(32'h2000_0040, 32'h3, 4'hF, 1'b1);
        drain_and_compare("R11");
        write_attr(32'h0000_0000);
    endtask

    task automatic t_fence;
        logic rdy;
        send(32'h3000_0000, 32'hE1, 4'hF);
        send(32'h3000_0004, 32'hE2, 4'hF);
        fence_req = 1'b1;
        #1;
        chk(fence_done == 1'b0, "R12", "fence pending with entries", 32'(fence_done), 32'h0);
        probe_ready(32'h3000_0004, rdy);
        chk(rdy == 1'b0, "R12", "store held during fence", 32'(rdy), 32'h0);
        @(negedge clk);
        expect_wr(32'h3000_0000, 32'hE1, 4'hF, 1'b0);
        expect_wr(32'h3000_0004, 32'hE2, 4'hF, 1'b0);
        drain_and_compare("R12");
        #1;
        chk(fence_done == 1'b1, "R12", "fence done after drain", 32'(fence_done), 32'h1);
        fence_req = 1'b0;
        #1;
        chk(fence_done == 1'b0, "R12", "fence done drops with request", 32'(fence_done), 32'h0);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        attr_we    = 1'b0;
        attr_wdata = '0;
        st_valid   = 1'b0;
        st_addr    = '0;
        st_data    = '0;
        st_strb    = '0;
        fence_req  = 1'b0;
        bus_ready  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_coalesce();
        t_bytes();
        t_volatile();
        write_attr(32'hAAAA_0000);
        t_full();
        t_attr_timing();
        write_attr(32'h0000_0000);
        t_cacheable();
        t_fence();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule